// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a blocking data cache with one entry per index. It sits between a processor that reads and writes single 32-bit words and a slower main memory that only moves whole 128-bit lines of four words. Each entry keeps a valid flag, a dirty flag and an address tag. A small state machine looks up each request. A hit is answered from the cache. On a miss it writes a modified victim line back to memory, fetches the wanted line, and then retries the lookup.

Writes that hit change only the cached copy and mark it modified. Writes that miss first bring the line in and then merge the new word into it. The processor holds its request until the cache answers with a one-cycle ready pulse. Main memory takes a request with a valid strobe and finishes it with a one-cycle ready pulse after a latency of its own choosing.

Top module: `wb_line_cache`

## Requirements
- R1: A byte address divides as follows. Bits [1:0] select a byte in the word and are ignored. Bits [3:2] select the word in the line, and word k sits at bits [32k+31:32k] of a line. The next log2(LINES) bits form the index. All remaining upper bits form the tag.
- R2: After reset no entry is valid. The first access to any line after a reset misses and issues a memory read. `cpu_ready` and `mem_valid` are low after reset.
- R3: A lookup hits only when the entry is valid and its tag equals the address tag. A read hit returns the word with `cpu_ready` high exactly two cycles after `cpu_valid` is first sampled, and it makes no memory transaction.
- R4: A write hit updates only the cached word and marks the line dirty. No memory write takes place, and a later read of that word returns the new value.
- R5: A miss on a dirty entry first writes the whole old line to the address formed from the old tag and the index (`mem_we`=1). Only after that write completes does it read the new line (`mem_we`=0).
- R6: A miss on a clean or invalid entry issues exactly one memory read and no memory write.
- R7: A write miss fetches the line and then merges the written word into it. The other three words keep their memory values.
- R8: During a miss `cpu_ready` stays low until the refill has completed and the access has been retried. A miss therefore takes more than two cycles. `cpu_ready` is never high for two cycles in a row.
- R9: `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` stay stable from the start of a memory request until the cycle in which `mem_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request strobe, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory request strobe |
| mem_we | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_addr | output | 32 | Line-aligned byte address |
| mem_wdata | output | 128 | Line being written back |
| mem_rdata | input | 128 | Fetched line, taken while `mem_ready` is high |
| mem_ready | input | 1 | One-cycle memory completion pulse |

## Verification
The assertions assume a processor that holds `cpu_valid` and its request fields steady until `cpu_ready` and then drops the strobe. They also assume a memory that raises `mem_ready` for only one cycle, and only while `mem_valid` is high. The bench keeps to both rules. Its processor task lowers `cpu_valid` on the same falling edge at which it sees the ready pulse. Its memory model counts a fixed latency only while a request is pending and clears its ready flag on the following falling edge.

// File: rtl/wb_cache_pkg.sv
package wb_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_REFILL
  } wbc_state_e;
endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 24,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             fill_en,
  input  logic             mark_dirty,
  output logic             lk_hit,
  output logic             lk_dirty,
  output logic [TAG_W-1:0] lk_vtag
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[lk_idx] <= 1'b1;
      dirty_q[lk_idx] <= 1'b0;
    end else if (mark_dirty) begin
      dirty_q[lk_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[lk_idx] <= lk_tag;
  end

  assign lk_hit   = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_dirty = valid_q[lk_idx] && dirty_q[lk_idx];
  assign lk_vtag  = tag_q[lk_idx];

  // R4: a modified entry is always a valid one
  assert_dirty_needs_valid_R4: assert property (@(posedge clk) disable iff (rst)
    (dirty_q & ~valid_q) == '0);

  // R3: a freshly filled entry hits on the same lookup
  assert_fill_then_hit_R3: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> lk_hit);
endmodule

// File: rtl/wbc_line_ram.sv
module wbc_line_ram #(
  parameter int LINES  = 16,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [LINE_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [LINE_W-1:0] q
);
  logic [LINE_W-1:0] mem [LINES];

  // synchronous read, write-first on a same-address collision
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (we && (waddr == raddr)) q <= wdata;
    else                        q <= mem[raddr];
  end
endmodule

// File: rtl/wb_line_cache.sv
module wb_line_cache
  import wb_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int LINES  = 16,
  localparam int LINE_W = WORD_W * WORDS,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int BSEL_W = $clog2(WORD_W / 8),
  localparam int OFF_W  = WSEL_W + BSEL_W,
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_ready
);
  wbc_state_e        state;
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_wsel;
  logic              req_we;
  logic [WORD_W-1:0] req_wdata;

  logic              tag_hit, vic_dirty, fill_done, wr_hit, ds_we;
  logic [TAG_W-1:0]  vic_tag;
  logic [IDX_W-1:0]  rd_idx;
  logic [LINE_W-1:0] line_q, merged, ds_wdata;

  assign fill_done = (state == ST_REFILL) && mem_ready;
  assign wr_hit    = (state == ST_LOOKUP) && tag_hit && req_we;
  assign ds_we     = fill_done || wr_hit;
  assign ds_wdata  = fill_done ? mem_rdata : merged;
  assign rd_idx    = (state == ST_IDLE) ? cpu_addr[OFF_W +: IDX_W] : req_idx;

  for (genvar w = 0; w < WORDS; w++) begin : g_merge
    assign merged[w*WORD_W +: WORD_W] =
      (req_wsel == WSEL_W'(w)) ? req_wdata : line_q[w*WORD_W +: WORD_W];
  end

  wbc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .lk_idx(req_idx), .lk_tag(req_tag),
    .fill_en(fill_done), .mark_dirty(wr_hit),
    .lk_hit(tag_hit), .lk_dirty(vic_dirty), .lk_vtag(vic_tag)
  );

  wbc_line_ram #(.LINES(LINES), .LINE_W(LINE_W)) u_lines (
    .clk(clk), .we(ds_we), .waddr(req_idx), .wdata(ds_wdata),
    .raddr(rd_idx), .q(line_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_ready <= 1'b0;
      unique case (state)
        ST_IDLE: if (cpu_valid) state <= ST_LOOKUP;
        ST_LOOKUP: begin
          if (tag_hit) begin
            state     <= ST_IDLE;
            cpu_ready <= 1'b1;
            if (!req_we) cpu_rdata <= line_q[req_wsel*WORD_W +: WORD_W];
          end else if (vic_dirty) begin
            state <= ST_EVICT;
          end else begin
            state <= ST_REFILL;
          end
        end
        ST_EVICT:  if (mem_ready) state <= ST_REFILL;
        ST_REFILL: if (mem_ready) state <= ST_LOOKUP;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == ST_IDLE && cpu_valid) begin
      req_tag   <= cpu_addr[ADDR_W-1 -: TAG_W];
      req_idx   <= cpu_addr[OFF_W +: IDX_W];
      req_wsel  <= cpu_addr[BSEL_W +: WSEL_W];
      req_we    <= cpu_we;
      req_wdata <= cpu_wdata;
    end
  end

  assign mem_valid = (state == ST_EVICT) || (state == ST_REFILL);
  assign mem_we    = (state == ST_EVICT);
  assign mem_addr  = {(state == ST_EVICT) ? vic_tag : req_tag, req_idx, {OFF_W{1'b0}}};
  assign mem_wdata = line_q;

  // R8: completion is a single-cycle pulse
  assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // R8: no completion while a memory transaction is open
  assert_stall_on_miss_R8: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !cpu_ready);

  // R9: memory request held steady until accepted
  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  // R5: a finished write-back is followed by a line fetch
  assert_evict_then_fetch_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EVICT && mem_ready) |=> (mem_valid && !mem_we));

  // R4: a write hit leaves the entry marked modified
  assert_write_hit_dirty_R4: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> vic_dirty);
endmodule

// File: tb/wb_line_cache_bench.sv
module wb_line_cache_bench;
  localparam int LAT   = 3;
  localparam int NWORD = 256;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_ready;
  logic         mem_valid, mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;
  logic         mem_ready = 1'b0;

  always #10 clk = ~clk;

  wb_line_cache #(.LINES(4)) u_wb_line_cache (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  logic [31:0] bm  [NWORD];
  logic [31:0] ref_w [NWORD];
  int n_rd = 0, n_wr = 0, mcnt = 0;
  logic [7:0]  seq = '0;
  logic [31:0] last_wr_addr = '0;
  int checks = 0, errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  function automatic logic [31:0] init_val(int i);
    return 32'h1000_0000 + i * 32'h0001_0003;
  endfunction

  // memory model: responds LAT cycles after a request appears
  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 1'b0;
      mcnt = 0;
    end else if (mem_valid === 1'b1) begin
      if (mcnt == LAT - 1) begin
        mcnt = 0;
        mem_ready = 1'b1;
        if (mem_we) begin
          for (int k = 0; k < 4; k++) bm[int'(mem_addr[9:4]) * 4 + k] = mem_wdata[32*k +: 32];
          n_wr++;
          last_wr_addr = mem_addr;
          seq = {seq[6:0], 1'b1};
        end else begin
          for (int k = 0; k < 4; k++) mem_rdata[32*k +: 32] = bm[int'(mem_addr[9:4]) * 4 + k];
          n_rd++;
          seq = {seq[6:0], 1'b0};
        end
      end else begin
        mcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!cpu_ready && lat < 200);
    rd = cpu_rdata;
    cpu_valid = 1'b0;
    if (we) ref_w[addr[9:2]] = wd;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int lat, r0, w0, bad;
    for (int i = 0; i < NWORD; i++) begin
      bm[i] = init_val(i);
      ref_w[i] = init_val(i);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cpu_ready == 1'b0, "R2 ready low after reset", {31'b0, cpu_ready}, 32'd0);
    chk(mem_valid == 1'b0, "R2 mem_valid low after reset", {31'b0, mem_valid}, 32'd0);

    // sweep reads over every word: cold and clean misses, then hits
    for (int w = 0; w < NWORD; w++) begin
      access(1'b0, 32'(w * 4), '0, rd, lat);
      chk(rd == ref_w[w], "R1 R3 read data", rd, ref_w[w]);
      if (w % 4 == 0) chk(lat > 2, "R8 miss stalls", lat, 32'd3);
      else            chk(lat == 2, "R3 hit latency", lat, 32'd2);
    end
    chk(n_rd == 64, "R2 R6 one fetch per line", n_rd, 32'd64);
    chk(n_wr == 0, "R6 clean miss writes nothing", n_wr, 32'd0);

    // write hit on cached line 63 (index 3)
    w0 = n_wr; r0 = n_rd;
    access(1'b1, 32'(252 * 4), 32'hDEAD_0001, rd, lat);
    chk(lat == 2, "R4 write hit latency", lat, 32'd2);
    chk(n_wr == w0 && n_rd == r0, "R4 no memory traffic", n_wr - w0 + n_rd - r0, 32'd0);
    chk(bm[252] == init_val(252), "R4 memory untouched", bm[252], init_val(252));
    access(1'b0, 32'(252 * 4), '0, rd, lat);
    chk(rd == 32'hDEAD_0001 && lat == 2, "R4 read back", rd, 32'hDEAD_0001);

    // dirty eviction by line 59, same index 3
    w0 = n_wr; r0 = n_rd;
    access(1'b0, 32'(236 * 4), '0, rd, lat);
    chk(rd == ref_w[236], "R5 data after eviction", rd, ref_w[236]);
    chk(n_wr == w0 + 1 && n_rd == r0 + 1, "R5 one write one read", n_wr - w0, 32'd1);
    chk(seq[1:0] == 2'b10, "R5 write before read", {30'b0, seq[1:0]}, 32'd2);
    chk(last_wr_addr == 32'd1008, "R5 victim address", last_wr_addr, 32'd1008);
    chk(bm[252] == 32'hDEAD_0001, "R5 modified word written", bm[252], 32'hDEAD_0001);
    chk(bm[253] == init_val(253) && bm[255] == init_val(255), "R5 full line", bm[253], init_val(253));

    // write miss on line 5 (index 1, clean occupant)
    w0 = n_wr; r0 = n_rd;
    access(1'b1, 32'(22 * 4), 32'hBEEF_0022, rd, lat);
    chk(lat > 2, "R8 write miss stalls", lat, 32'd3);
    chk(n_rd == r0 + 1 && n_wr == w0, "R7 R6 allocate fetch", n_rd - r0, 32'd1);
    for (int w = 20; w < 24; w++) begin
      access(1'b0, 32'(w * 4), '0, rd, lat);
      chk(rd == ref_w[w] && lat == 2, "R7 merged line", rd, ref_w[w]);
    end
    chk(bm[22] == init_val(22), "R4 write miss not written through", bm[22], init_val(22));
    access(1'b0, 32'(22 * 4 + 3), '0, rd, lat);
    chk(rd == 32'hBEEF_0022, "R1 byte bits ignored", rd, 32'hBEEF_0022);

    // write sweep then read sweep, with many dirty evictions
    for (int w = 0; w < NWORD; w++) access(1'b1, 32'(w * 4), 32'h5A5A_0000 ^ 32'(w * 7), rd, lat);
    bad = 0;
    for (int w = 0; w < NWORD; w++) begin
      access(1'b0, 32'(w * 4), '0, rd, lat);
      if (rd != ref_w[w]) bad++;
    end
    chk(bad == 0, "R3 R7 write sweep read back", bad, 32'd0);
    bad = 0;
    for (int w = 0; w < NWORD; w++) if (bm[w] != ref_w[w]) bad++;
    chk(bad == 0, "R5 memory holds written lines", bad, 32'd0);

    // reset invalidates: a previously cached line misses again
    do_reset();
    r0 = n_rd;
    access(1'b0, 32'(252 * 4), '0, rd, lat);
    chk(lat > 2 && n_rd == r0 + 1, "R2 miss after reset", lat, 32'd3);
    chk(rd == ref_w[252], "R2 data after reset", rd, ref_w[252]);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule